// File: doc/BRIEF.md
# Device configuration sequencer

This block steers a programmable logic device from power-up, or from a reconfiguration request, into user operation. It watches a supply-good flag, an active-low program request and the sensed level of an open-drain INIT line. It drives INIT low, DONE, an I/O enable and the release of the global set/reset. The flow runs in a fixed order. First it clears the configuration memory by walking every frame address. Next it waits for any external delay to end. It then latches the three mode inputs and takes in the frame bytes over a valid/ready stream while it checks a CRC. If the CRC is good it runs a three-step start-up.

A reconfiguration from user operation is acknowledged by dropping DONE before the clear begins. A program request held low stalls the flow at the end of the clear. An INIT line held low from outside stalls it before the mode inputs are sampled. A CRC mismatch leaves the device in an error state with INIT pulled low until the next program request. The supply-good and program inputs pass through two-flop synchronisers. The INIT sense and the data stream are taken as already synchronous.

Top module: `cfgseq_top`

## Requirements
- R1: While reset is high, and afterwards for as long as supply_ok stays low, init_drive_low is 1 and done, io_enable, gsr_release, din_ready and clr_strobe are all 0.
- R2: After supply_ok rises, clr_strobe is high for exactly CLEAR_FRAMES cycles in a row. clr_addr runs 0, 1, ... CLEAR_FRAMES-1, one address per cycle, and init_drive_low stays 1 throughout.
- R3: When prog_n goes low in user operation, done falls first. During that acknowledge cycle clr_strobe is 0 and init_drive_low is 1. The clear walk begins at address 0 in the next cycle.
- R4: While prog_n is held low, the flow stays at the end of the clear with init_drive_low at 1 and din_ready at 0, whatever the length of the hold.
- R5: After the clear, init_drive_low goes to 0. If init_sense is held low from outside, din_ready stays 0 until init_sense reads 1.
- R6: mode_latched takes the value of mode_pins from the cycle after init_sense is seen high. It keeps that value when mode_pins change later.
- R7: din_ready is 1 only in the load phase. One byte is taken per cycle in which din_valid and din_ready are both 1. The first FRAME_BYTES bytes feed a CRC-16 with polynomial 0x8005 and initial value 0. Bits are taken MSB first, with no reflection and no final XOR. The next two bytes give the expected CRC, high byte first.
- R8: When the CRC matches, done is 1 right after the edge that accepts the last check byte. io_enable follows one cycle later and gsr_release one cycle after that, and all three then stay high.
- R9: On a CRC mismatch, init_drive_low becomes 1 right after the last check byte. done, io_enable, gsr_release and din_ready stay 0 until prog_n goes low.
- R10: A program request in the error state restarts the flow with a full clear walk. A later frame with a correct CRC reaches user operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Supplies reported good (asynchronous) |
| prog_n | input | 1 | Active-low program request (asynchronous) |
| init_sense | input | 1 | Sensed level of the open-drain INIT line |
| mode_pins | input | 3 | Configuration mode inputs |
| din_valid | input | 1 | Frame byte valid |
| din_data | input | 8 | Frame byte |
| din_ready | output | 1 | Sequencer accepts a byte |
| init_drive_low | output | 1 | Pull the INIT line low |
| done | output | 1 | DONE level |
| io_enable | output | 1 | User I/O enable |
| gsr_release | output | 1 | Global set/reset released |
| clr_strobe | output | 1 | Clear one frame address this cycle |
| clr_addr | output | CLEAR_AW | Frame address being cleared |
| mode_latched | output | 3 | Mode captured for the load phase |

## Verification
The bench holds the program request low well past the end of the clear walk. A design that left the clear on its own would raise din_ready during the hold. It also holds INIT low from outside after the clear, so a sequencer that ignored the sensed line would start loading too early. The mode pins change after they have been sampled, which catches a latch that follows the pins. A frame with a corrupted check byte must end in the error state with INIT low. A start-up that raises the three outputs together or out of order, or that starts one cycle late, is caught by checks made cycle by cycle after the last byte.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

    localparam logic [15:0] CRC_POLY = 16'h8005;

    typedef enum logic [3:0] {
        ST_OFF,
        ST_ACK,
        ST_CLEAR,
        ST_WAIT_INIT,
        ST_MODE,
        ST_LOAD,
        ST_START_DONE,
        ST_START_IO,
        ST_USER,
        ST_ERROR
    } cfg_state_e;

    typedef struct packed {
        logic init_low;
        logic done;
        logic io_en;
        logic gsr_rel;
    } pin_drive_t;

    function automatic logic [15:0] crc16_step(input logic [15:0] cur, input logic [7:0] data);
        logic [15:0] r;
        logic        fb;
        r = cur;
        for (int i = 7; i >= 0; i--) begin
            fb = r[15] ^ data[i];
            r  = {r[14:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction

    function automatic pin_drive_t decode_pins(input cfg_state_e st);
        pin_drive_t p;
        p = '{init_low: 1'b0, done: 1'b0, io_en: 1'b0, gsr_rel: 1'b0};
        case (st)
            ST_OFF, ST_ACK, ST_CLEAR, ST_ERROR: p.init_low = 1'b1;
            ST_START_DONE: p.done = 1'b1;
            ST_START_IO:   begin p.done = 1'b1; p.io_en = 1'b1; end
            ST_USER:       begin p.done = 1'b1; p.io_en = 1'b1; p.gsr_rel = 1'b1; end
            default:       p.init_low = 1'b0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/cfgseq_sync.sv
module cfgseq_sync #(
    parameter int         WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/cfgseq_clear.sv
module cfgseq_clear #(
    parameter int CLEAR_FRAMES = 16,
    localparam int AW = (CLEAR_FRAMES > 1) ? $clog2(CLEAR_FRAMES) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    output logic          strobe,
    output logic [AW-1:0] addr,
    output logic          finished
);
    localparam logic [AW-1:0] LAST = AW'(CLEAR_FRAMES - 1);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            addr     <= '0;
            finished <= 1'b0;
        end else if (!finished) begin
            if (addr == LAST) finished <= 1'b1;
            else              addr     <= addr + AW'(1);
        end
    end

    assign strobe = run && !finished;

    AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        strobe |-> addr <= LAST) else $error("clear address past end"); // R2

    AST_ADDR_STEPS: assert property (@(posedge clk) disable iff (rst)
        (strobe && $past(strobe)) |-> addr == $past(addr) + AW'(1)) else $error("clear address skipped"); // R2
endmodule

// File: rtl/cfgseq_crc.sv
module cfgseq_crc
    import cfgseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  data,
    output logic [15:0] crc
);
    always_ff @(posedge clk) begin
        if (rst || clr) crc <= '0;
        else if (en)    crc <= crc16_step(crc, data);
    end
endmodule

// File: rtl/cfgseq_top.sv
module cfgseq_top
    import cfgseq_pkg::*;
#(
    parameter int FRAME_BYTES  = 8,
    parameter int CLEAR_FRAMES = 16,
    localparam int CLEAR_AW = (CLEAR_FRAMES > 1) ? $clog2(CLEAR_FRAMES) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                supply_ok,
    input  logic                prog_n,
    input  logic                init_sense,
    input  logic [2:0]          mode_pins,
    input  logic                din_valid,
    input  logic [7:0]          din_data,
    output logic                din_ready,
    output logic                init_drive_low,
    output logic                done,
    output logic                io_enable,
    output logic                gsr_release,
    output logic                clr_strobe,
    output logic [CLEAR_AW-1:0] clr_addr,
    output logic [2:0]          mode_latched
);
    localparam int CW = $clog2(FRAME_BYTES + 2);
    localparam logic [CW-1:0] HI_IDX = CW'(FRAME_BYTES);
    localparam logic [CW-1:0] LO_IDX = CW'(FRAME_BYTES + 1);

    cfg_state_e  state;
    pin_drive_t  pins;
    logic [1:0]  sync_q;
    logic        sup_s, prog_s;
    logic        clr_fin, hs, crc_en;
    logic [CW-1:0] cnt;
    logic [7:0]  crc_hi;
    logic [15:0] crc_val;

    cfgseq_sync #(.WIDTH(2), .RST_VAL(2'b10)) u_sync (
        .clk(clk), .rst(rst), .d({prog_n, supply_ok}), .q(sync_q)
    );
    assign sup_s  = sync_q[0];
    assign prog_s = sync_q[1];

    cfgseq_clear #(.CLEAR_FRAMES(CLEAR_FRAMES)) u_clear (
        .clk(clk), .rst(rst), .run(state == ST_CLEAR),
        .strobe(clr_strobe), .addr(clr_addr), .finished(clr_fin)
    );

    assign din_ready = (state == ST_LOAD);
    assign hs        = din_valid && din_ready;
    assign crc_en    = hs && (cnt < HI_IDX);

    cfgseq_crc u_crc (
        .clk(clk), .rst(rst), .clr(state == ST_MODE), .en(crc_en),
        .data(din_data), .crc(crc_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_OFF;
            cnt          <= '0;
            crc_hi       <= '0;
            mode_latched <= '0;
        end else begin
            case (state)
                ST_OFF:       if (sup_s) state <= ST_CLEAR;
                ST_ACK:       state <= ST_CLEAR;
                ST_CLEAR:     if (clr_fin && prog_s) state <= ST_WAIT_INIT;
                ST_WAIT_INIT: if (init_sense) state <= ST_MODE;
                ST_MODE: begin
                    mode_latched <= mode_pins;
                    cnt          <= '0;
                    state        <= ST_LOAD;
                end
                ST_LOAD: if (hs) begin
                    if (cnt == LO_IDX) begin
                        state <= ({crc_hi, din_data} == crc_val) ? ST_START_DONE : ST_ERROR;
                    end else begin
                        if (cnt == HI_IDX) crc_hi <= din_data;
                        cnt <= cnt + CW'(1);
                    end
                end
                ST_START_DONE: state <= ST_START_IO;
                ST_START_IO:   state <= ST_USER;
                ST_USER:       if (!prog_s) state <= ST_ACK;
                ST_ERROR:      if (!prog_s) state <= ST_ACK;
                default:       state <= ST_OFF;
            endcase
        end
    end

    always_comb pins = decode_pins(state);
    assign init_drive_low = pins.init_low;
    assign done           = pins.done;
    assign io_enable      = pins.io_en;
    assign gsr_release    = pins.gsr_rel;

    AST_IO_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(io_enable) |-> $past(done)) else $error("io before done"); // R8

    AST_GSR_AFTER_IO: assert property (@(posedge clk) disable iff (rst)
        $rose(gsr_release) |-> $past(io_enable)) else $error("gsr before io"); // R8

    AST_READY_ONLY_RELEASED: assert property (@(posedge clk) disable iff (rst)
        din_ready |-> (!init_drive_low && !done)) else $error("ready outside load"); // R7

    AST_CLEAR_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        $rose(clr_strobe) |-> (!done && init_drive_low)) else $error("clear without ack"); // R3

    AST_PROG_HOLDS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT_INIT && $past(state) == ST_CLEAR) |-> $past(prog_s)) else $error("left clear under hold"); // R4

    AST_ERROR_KEEPS_INIT: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == ST_ERROR && $past(prog_s)) |-> (init_drive_low && !done)) else $error("error released"); // R9
endmodule

// File: tb/tb_cfgseq_top.sv
module tb_cfgseq_top;
    localparam int FB = 8;
    localparam int NF = 16;
    localparam int AW = $clog2(NF);

    logic clk = 0, rst = 1;
    logic supply_ok = 0, prog_n = 1, ext_hold = 0;
    logic [2:0] mode_pins = 3'b101;
    logic din_valid = 0;
    logic [7:0] din_data = 0;
    logic din_ready, init_drive_low, done, io_enable, gsr_release, clr_strobe, init_sense;
    logic [AW-1:0] clr_addr;
    logic [2:0] mode_latched;

    int total = 0, fails = 0, cycles = 0;
    int exp_addr[$];

    assign init_sense = !init_drive_low && !ext_hold;

    cfgseq_top #(.FRAME_BYTES(FB), .CLEAR_FRAMES(NF)) dut (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .prog_n(prog_n),
        .init_sense(init_sense), .mode_pins(mode_pins), .din_valid(din_valid),
        .din_data(din_data), .din_ready(din_ready), .init_drive_low(init_drive_low),
        .done(done), .io_enable(io_enable), .gsr_release(gsr_release),
        .clr_strobe(clr_strobe), .clr_addr(clr_addr), .mode_latched(mode_latched)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c ^ {d, 8'h00};
        for (int k = 0; k < 8; k++) r = r[15] ? ((r << 1) ^ 16'h8005) : (r << 1);
        return r;
    endfunction

    task automatic push_clear();
        for (int a = 0; a < NF; a++) exp_addr.push_back(a);
    endtask

    // scoreboard monitor: every strobe pops the next expected address
    always @(negedge clk) begin
        if (!rst && clr_strobe) begin
            if (exp_addr.size() == 0) check("R2 unexpected strobe", clr_addr, 32'hFFFF);
            else check("R2 clear address", clr_addr, exp_addr.pop_front());
            check("R2 init low in clear", init_drive_low, 1);
        end
    end

    task automatic wait_ready();
        @(negedge clk);
        for (int n = 0; n < 500 && !din_ready; n++) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        while (!din_ready) @(negedge clk);
        din_valid = 1; din_data = b;
        @(negedge clk);
        din_valid = 0;
    endtask

    task automatic send_frame(input logic [7:0] seed, input bit corrupt);
        logic [15:0] c;
        logic [7:0] b;
        c = 0;
        for (int i = 0; i < FB; i++) begin
            b = seed + 8'(i * 37) ^ 8'h5A;
            c = ref_crc(c, b);
            send_byte(b);
        end
        if (corrupt) c = c ^ 16'h0001;
        send_byte(c[15:8]);
        send_byte(c[7:0]);
    endtask

    task automatic check_startup(input string tag);
        check({tag, " done after last byte"}, {done, io_enable, gsr_release}, 3'b100);
        @(negedge clk);
        check({tag, " io next"}, {done, io_enable, gsr_release}, 3'b110);
        @(negedge clk);
        check({tag, " gsr next"}, {done, io_enable, gsr_release}, 3'b111);
    endtask

    initial begin
        repeat (3000) @(posedge clk);
        // long waits below are bounded, this guards against a hang
        repeat (97000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1 reset pins", {init_drive_low, done, io_enable, gsr_release, din_ready, clr_strobe}, 6'b100000);
        rst = 0;
        repeat (6) @(negedge clk);
        check("R1 supply low", {init_drive_low, done, io_enable, gsr_release, din_ready, clr_strobe}, 6'b100000);

        // power-up with INIT held externally
        push_clear();
        ext_hold = 1;
        supply_ok = 1;
        for (int n = 0; n < 200 && init_drive_low; n++) @(negedge clk);
        check("R2 clear walk complete", exp_addr.size(), 0);
        check("R5 drive released", init_drive_low, 0);
        repeat (8) @(negedge clk);
        check("R5 no ready while init held", din_ready, 0);
        ext_hold = 0;
        wait_ready();
        check("R5 ready after init release", din_ready, 1);
        check("R6 mode latched", mode_latched, 3'b101);
        mode_pins = 3'b010;
        send_frame(8'h11, 0);
        check_startup("R8");
        check("R6 mode held", mode_latched, 3'b101);
        repeat (5) @(negedge clk);
        check("R8 user stays", {done, io_enable, gsr_release}, 3'b111);

        // reconfiguration with a long program hold
        push_clear();
        prog_n = 0;
        for (int n = 0; n < 20 && done; n++) @(negedge clk);
        check("R3 done drops", done, 0);
        check("R3 ack cycle no strobe", clr_strobe, 0);
        check("R3 ack init low", init_drive_low, 1);
        @(negedge clk);
        check("R3 walk starts", clr_strobe, 1);
        repeat (50) @(negedge clk);
        check("R4 hold keeps init low", init_drive_low, 1);
        check("R4 hold keeps ready low", din_ready, 0);
        check("R3 second walk complete", exp_addr.size(), 0);
        prog_n = 1;
        wait_ready();
        check("R6 new mode latched", mode_latched, 3'b010);

        // bad CRC
        send_frame(8'hC3, 1);
        check("R9 abort pins", {init_drive_low, done, io_enable, gsr_release, din_ready}, 5'b10000);
        check("R9 init line low", init_sense, 0);
        din_valid = 1; din_data = 8'hAA;
        repeat (20) @(negedge clk);
        din_valid = 0;
        check("R9 error persists", {init_drive_low, done, io_enable, gsr_release, din_ready}, 5'b10000);

        // recovery
        push_clear();
        prog_n = 0;
        repeat (3) @(negedge clk);
        prog_n = 1;
        wait_ready();
        check("R10 clear rerun", exp_addr.size(), 0);
        check("R7 ready in load", din_ready, 1);
        send_frame(8'h7E, 0);
        check_startup("R10");
        check("R7 ready off after load", din_ready, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    always @(posedge clk) cycles++;
endmodule